// File: doc/BRIEF.md
# Mirrored Channel Interrupt Status Bank

This block is the interrupt-status corner of the configuration space of a two-channel disk controller. Each channel has one pending flag. Software can see that flag in two places: in a per-channel status byte, and in a shared mode byte that also holds the per-channel interrupt block bits. Whichever place software clears, and whenever a channel's request line moves, both places show the same value from the next cycle on.

Configuration accesses use a dword index with a 32-bit data word and four byte enables. Byte lane k of dword index n is byte offset 4n+k. A second, byte-wide write port reaches the mode byte from the bus-master I/O window and may only change the two block bits. The single level-sensitive interrupt output is high while any channel is pending and not blocked. A parameter selects whether channel 1 comes out of reset enabled in the control byte.

Top module: `ide_irq_mirror`

## Requirements
- R1: After reset the bytes at offsets 0x50, 0x57 and 0x71 read 0x00, `irq_out` is low, and offset 0x51 reads 0x04, or 0x0C when `CH1_ON` is set (the default).
- R2: A rising edge on `chan_irq[0]` sets bit 2 of offset 0x50 and bit 2 of offset 0x71. A rising edge on `chan_irq[1]` sets bit 4 of offset 0x57 and bit 3 of offset 0x71. Both views are set together, one clock after the edge.
- R3: A falling edge on a channel's request clears both views of that channel's flag one clock later.
- R4: A configuration write that sets bit 2 at 0x50, or bit 4 at 0x57, clears that channel's flag in both views. A 0 in that bit has no effect, and a request line that stays high does not set the flag again.
- R5: A configuration write to 0x71 clears channel 0's flag for a 1 in bit 2 and channel 1's flag for a 1 in bit 3, in both views.
- R6: Configuration writes change no other bit of 0x50, 0x57 or 0x71. In particular, the block bits (bits 5:4 of 0x71) cannot be written from configuration space.
- R7: A write on the bus-master port loads bits 5:4 of 0x71 from `bm_wdata[5:4]` and leaves the pending bits unchanged.
- R8: `irq_out` is high exactly when channel 0 is pending with bit 4 of 0x71 clear, or channel 1 is pending with bit 5 of 0x71 clear.
- R9: Only byte lanes whose enable is set are written. A disabled lane at a status offset changes nothing.
- R10: If a request edge and a configuration clear of the same channel fall in the same cycle, the edge wins. A clear of the other channel in that write still applies.
- R11: Bits 3:2 of offset 0x51 hold the channel enables and are writable. The other bits of that byte read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw | input | 6 | Configuration dword index; also selects the read data |
| cfg_wdata | input | 32 | Configuration write data, byte lane k = bits 8k+7:8k |
| cfg_be | input | 4 | Configuration byte enables |
| cfg_rdata | output | 32 | Configuration read data for the dword at `cfg_dw` |
| bm_wr | input | 1 | Mode-byte write strobe from the bus-master window |
| bm_wdata | input | 8 | Mode-byte write data; only bits 5:4 are used |
| chan_irq | input | 2 | Channel interrupt request levels |
| irq_out | output | 1 | Level interrupt to the host |

## Verification
On every cycle, the assertions check that the status-byte copy and the mode-byte copy of each flag agree. They also check that a request edge leaves the flag at the new level, that a clear from either view takes effect when no edge collides with it, and that the block bits move only on a bus-master write. Only the bench scenarios can show the software view: the exact byte values read back, which byte lanes are ignored, the write-only-bits-5:4 rule of the second port, the masking effect on `irq_out`, and the edge-wins outcome together with the independent clear of the other channel in the same write.

// File: rtl/ide_irq_mirror.sv
module ide_irq_mirror #(
  parameter bit CH1_ON = 1'b1,
  parameter int DW     = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_wr,
  input  logic [7-$clog2(DW/8):0]        cfg_dw,
  input  logic [DW-1:0]                  cfg_wdata,
  input  logic [DW/8-1:0]                cfg_be,
  output logic [DW-1:0]                  cfg_rdata,
  input  logic                           bm_wr,
  input  logic [7:0]                     bm_wdata,
  input  logic [1:0]                     chan_irq,
  output logic                           irq_out
);

  localparam int NLANE = DW / 8;
  localparam logic [7:0] OFF_ST0  = 8'h50;
  localparam logic [7:0] OFF_CTL  = 8'h51;
  localparam logic [7:0] OFF_ST1  = 8'h57;
  localparam logic [7:0] OFF_MODE = 8'h71;
  localparam int ST0_BIT  = 2;
  localparam int ST1_BIT  = 4;
  localparam int MP0_BIT  = 2;
  localparam int MP1_BIT  = 3;
  localparam int BLK_LSB  = 4;
  localparam int CTL_LSB  = 2;
  localparam logic [1:0] CTL_RST = {CH1_ON, 1'b1};

  logic       st0, st1, mp0, mp1;
  logic [1:0] blk, ctl, irq_q;
  logic       st0_n, st1_n, mp0_n, mp1_n;
  logic [1:0] evt;

  logic       w_st0, c_st0, w_st1, c_st1, w_md, w_ctl;
  logic [1:0] c_md, d_ctl;

  logic unused_data;
  assign unused_data = ^{cfg_wdata, bm_wdata[7:6], bm_wdata[3:0]};

  assign evt = chan_irq ^ irq_q;

  always_comb begin
    logic [7:0] off;
    w_st0 = 1'b0; c_st0 = 1'b0;
    w_st1 = 1'b0; c_st1 = 1'b0;
    w_md  = 1'b0; c_md  = 2'b00;
    w_ctl = 1'b0; d_ctl = 2'b00;
    off   = 8'h00;
    for (int k = 0; k < NLANE; k++) begin
      off = 8'(int'(cfg_dw) * NLANE + k);
      if (cfg_wr && cfg_be[k]) begin
        case (off)
          OFF_ST0: begin
            w_st0 = 1'b1;
            c_st0 = cfg_wdata[8*k+ST0_BIT];
          end
          OFF_ST1: begin
            w_st1 = 1'b1;
            c_st1 = cfg_wdata[8*k+ST1_BIT];
          end
          OFF_MODE: begin
            w_md = 1'b1;
            c_md = {cfg_wdata[8*k+MP1_BIT], cfg_wdata[8*k+MP0_BIT]};
          end
          OFF_CTL: begin
            w_ctl = 1'b1;
            d_ctl = cfg_wdata[8*k+CTL_LSB +: 2];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    st0_n = st0;
    st1_n = st1;
    mp0_n = mp0;
    mp1_n = mp1;
    if (w_st0 || w_st1) begin
      if (w_st0 && c_st0) st0_n = 1'b0;
      if (w_st1 && c_st1) st1_n = 1'b0;
      mp0_n = st0_n;
      mp1_n = st1_n;
    end
    if (w_md) begin
      if (c_md[0]) mp0_n = 1'b0;
      if (c_md[1]) mp1_n = 1'b0;
      st0_n = mp0_n;
      st1_n = mp1_n;
    end
    if (evt[0]) mp0_n = chan_irq[0];
    if (evt[1]) mp1_n = chan_irq[1];
    if (evt != 2'b00) begin
      st0_n = mp0_n;
      st1_n = mp1_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0   <= 1'b0;
      st1   <= 1'b0;
      mp0   <= 1'b0;
      mp1   <= 1'b0;
      blk   <= 2'b00;
      ctl   <= CTL_RST;
      irq_q <= 2'b00;
    end else begin
      st0   <= st0_n;
      st1   <= st1_n;
      mp0   <= mp0_n;
      mp1   <= mp1_n;
      irq_q <= chan_irq;
      if (bm_wr) blk <= bm_wdata[BLK_LSB +: 2];
      if (w_ctl) ctl <= d_ctl;
    end
  end

  assign irq_out = (mp0 & ~blk[0]) | (mp1 & ~blk[1]);

  always_comb begin
    logic [7:0] off;
    off = 8'h00;
    cfg_rdata = '0;
    for (int k = 0; k < NLANE; k++) begin
      off = 8'(int'(cfg_dw) * NLANE + k);
      case (off)
        OFF_ST0:  cfg_rdata[8*k +: 8] = 8'(st0) << ST0_BIT;
        OFF_CTL:  cfg_rdata[8*k +: 8] = 8'(ctl) << CTL_LSB;
        OFF_ST1:  cfg_rdata[8*k +: 8] = 8'(st1) << ST1_BIT;
        OFF_MODE: cfg_rdata[8*k +: 8] = (8'(blk) << BLK_LSB) |
                                        (8'(mp1) << MP1_BIT) |
                                        (8'(mp0) << MP0_BIT);
        default:  cfg_rdata[8*k +: 8] = 8'h00;
      endcase
    end
  end

  // R4 R5
  views_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st0 == mp0) && (st1 == mp1));

  // R2
  rise_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[0] && chan_irq[0]) |=> (mp0 && st0));

  // R3
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[1] && !chan_irq[1]) |=> (!mp1 && !st1));

  // R4
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_st0 && c_st0 && !evt[0]) |=> !mp0);

  // R5
  mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w_md && c_md[1] && !evt[1]) |=> !st1);

  // R7
  block_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bm_wr |=> $stable(blk));

  // R10
  edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt[1] && chan_irq[1] && w_st1 && c_st1) |=> st1);

endmodule

// File: tb/test_ide_irq_mirror.sv
module test_ide_irq_mirror;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [5:0]  cfg_dw = '0;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic        bm_wr = 1'b0;
  logic [7:0]  bm_wdata = '0;
  logic [1:0]  chan_irq = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ide_irq_mirror i_ide_irq_mirror (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw(cfg_dw),
    .cfg_wdata(cfg_wdata), .cfg_be(cfg_be), .cfg_rdata(cfg_rdata),
    .bm_wr(bm_wr), .bm_wdata(bm_wdata), .chan_irq(chan_irq), .irq_out(irq_out)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] off, output logic [7:0] v);
    cfg_dw = off[7:2];
    #1;
    v = cfg_rdata[8*off[1:0] +: 8];
  endtask

  task automatic chkb(input string req, input logic [7:0] off, input logic [7:0] exp);
    logic [7:0] v;
    rd(off, v);
    chk(req, $sformatf("byte 0x%0h", off), int'(v), int'(exp));
  endtask

  task automatic chk_irq(input string req, input logic exp);
    chk(req, "irq_out", int'(irq_out), int'(exp));
  endtask

  task automatic views(input string req);
    logic [7:0] a, b, m;
    rd(8'h50, a);
    rd(8'h57, b);
    rd(8'h71, m);
    chk(req, "ch0 views agree", int'(a[2]), int'(m[2]));
    chk(req, "ch1 views agree", int'(b[4]), int'(m[3]));
  endtask

  task automatic cfgw(input logic [7:0] off, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_dw = off[7:2]; cfg_wdata = d; cfg_be = be; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic wbyte(input logic [7:0] off, input logic [7:0] b);
    cfgw(off, 32'(b) << (8 * off[1:0]), 4'b0001 << off[1:0]);
  endtask

  task automatic set_irq(input logic [1:0] v);
    @(negedge clk);
    chan_irq = v;
    @(negedge clk);
  endtask

  task automatic bmw(input logic [7:0] v);
    @(negedge clk);
    bm_wr = 1'b1; bm_wdata = v;
    @(negedge clk);
    bm_wr = 1'b0;
  endtask

  task automatic t_reset;
    chkb("R1", 8'h50, 8'h00);
    chkb("R1", 8'h57, 8'h00);
    chkb("R1", 8'h71, 8'h00);
    chkb("R1", 8'h51, 8'h0C);
    chk_irq("R1", 1'b0);
  endtask

  task automatic t_raise;
    set_irq(2'b01);
    chkb("R2", 8'h50, 8'h04);
    chkb("R2", 8'h71, 8'h04);
    chk_irq("R8", 1'b1);
    set_irq(2'b11);
    chkb("R2", 8'h57, 8'h10);
    chkb("R2", 8'h71, 8'h0C);
    views("R2");
  endtask

  task automatic t_fall;
    set_irq(2'b10);
    chkb("R3", 8'h50, 8'h00);
    chkb("R3", 8'h71, 8'h08);
    chkb("R3", 8'h57, 8'h10);
    set_irq(2'b00);
    chkb("R3", 8'h57, 8'h00);
    chkb("R3", 8'h71, 8'h00);
    chk_irq("R3", 1'b0);
  endtask

  task automatic t_status_clear;
    set_irq(2'b11);
    wbyte(8'h50, 8'h00);
    chkb("R4", 8'h50, 8'h04);
    wbyte(8'h50, 8'hFB);
    chkb("R6", 8'h50, 8'h04);
    wbyte(8'h50, 8'hFF);
    chkb("R4", 8'h50, 8'h00);
    chkb("R4", 8'h71, 8'h08);
    chk_irq("R4", 1'b1);
    wbyte(8'h57, 8'hEF);
    chkb("R6", 8'h57, 8'h10);
    wbyte(8'h57, 8'hFF);
    chkb("R4", 8'h57, 8'h00);
    chkb("R4", 8'h71, 8'h00);
    chk_irq("R4", 1'b0);
    @(negedge clk);
    chkb("R4", 8'h71, 8'h00);
    set_irq(2'b00);
  endtask

  task automatic t_mode_clear;
    set_irq(2'b11);
    wbyte(8'h71, 8'h08);
    chkb("R5", 8'h71, 8'h04);
    chkb("R5", 8'h57, 8'h00);
    chkb("R5", 8'h50, 8'h04);
    wbyte(8'h71, 8'hF3);
    chkb("R6", 8'h71, 8'h04);
    wbyte(8'h71, 8'h04);
    chkb("R5", 8'h71, 8'h00);
    chkb("R5", 8'h50, 8'h00);
    views("R5");
    set_irq(2'b00);
  endtask

  task automatic t_lanes;
    set_irq(2'b11);
    cfgw(8'h50, 32'hFFFF_FFFF, 4'b1110);
    chkb("R9", 8'h50, 8'h04);
    chkb("R11", 8'h51, 8'h0C);
    cfgw(8'h54, 32'hFFFF_FFFF, 4'b0111);
    chkb("R9", 8'h57, 8'h10);
    cfgw(8'h54, 32'hFFFF_FFFF, 4'b1000);
    chkb("R9", 8'h57, 8'h00);
    wbyte(8'h51, 8'h00);
    chkb("R11", 8'h51, 8'h00);
    wbyte(8'h51, 8'hF7);
    chkb("R11", 8'h51, 8'h04);
    wbyte(8'h51, 8'h0C);
    chkb("R11", 8'h51, 8'h0C);
    set_irq(2'b00);
  endtask

  task automatic t_block;
    set_irq(2'b01);
    chk_irq("R8", 1'b1);
    bmw(8'hFF);
    chkb("R7", 8'h71, 8'h34);
    chk_irq("R8", 1'b0);
    wbyte(8'h71, 8'h30);
    chkb("R6", 8'h71, 8'h34);
    bmw(8'h10);
    chkb("R7", 8'h71, 8'h14);
    chk_irq("R8", 1'b0);
    set_irq(2'b11);
    chk_irq("R8", 1'b1);
    bmw(8'h20);
    chk_irq("R8", 1'b1);
    bmw(8'h00);
    chkb("R7", 8'h71, 8'h0C);
    set_irq(2'b00);
    chk_irq("R8", 1'b0);
  endtask

  task automatic t_collide;
    set_irq(2'b00);
    @(negedge clk);
    chan_irq = 2'b10;
    cfg_dw = 6'h15; cfg_wdata = 32'hFF00_0000; cfg_be = 4'b1000; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    chkb("R10", 8'h57, 8'h10);
    chkb("R10", 8'h71, 8'h08);
    @(negedge clk);
    chan_irq = 2'b11;
    cfg_dw = 6'h1C; cfg_wdata = 32'h0000_0C00; cfg_be = 4'b0010; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
    chkb("R10", 8'h71, 8'h04);
    chkb("R10", 8'h50, 8'h04);
    chkb("R10", 8'h57, 8'h00);
    views("R10");
    set_irq(2'b00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_raise();
    t_fall();
    t_status_clear();
    t_mode_clear();
    t_lanes();
    t_block();
    t_collide();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule